// File: doc/BRIEF.md
# Per-Phase Audio FIFO Status Controller

This block sits between the bit shifter of an audio serial port and the host for one frame phase (left or right). It holds two first-in first-out buffers. The receive buffer is filled by the shifter and drained by the host. The transmit buffer is filled by the host and drained by the shifter. Each buffer reports its fill level continuously.

The receive buffer is flagged as full when its level reaches a programmable threshold. The transmit buffer is flagged as empty when its level drops to a programmable threshold. The block also records three error conditions: samples lost to a full receive buffer, reads from an empty transmit buffer, and framing errors reported by the shifter. These error records are sticky. A single interrupt line combines the status bits through a per-bit enable mask.

A small write-only register port sets the buffer enables, both thresholds and the interrupt mask, and clears the sticky bits. A threshold write outside the legal range is refused. The port reports the reason: too high or too low.

Top module: `audio_phase_fifo_ctrl`

## Requirements
- R1: After reset both levels are 0, `status_o` is 0, `irq_o` is 0, `cfg_err_o` is 0 and both buffers are disabled.
- R2: Each enabled buffer delivers its samples in arrival order. The head sample appears on the read data port while the level is nonzero. The level port counts the stored samples, is updated one cycle after a push or pop, and never exceeds DEPTH.
- R3: Writing address 0 sets the enables: bit 0 for receive, bit 1 for transmit. While a buffer's enable is 0 it is flushed to level 0, ignores pushes and pops, raises no overrun or underrun, and its threshold bit reads 0.
- R4: Status bit 0 (receive full) is 1 exactly when the receive buffer is enabled and its level is greater than or equal to the receive threshold.
- R5: Status bit 1 (transmit empty) is 1 exactly when the transmit buffer is enabled and its level is less than or equal to the transmit threshold.
- R6: A write to address 1 (receive threshold) or address 2 (transmit threshold) behaves as follows:
  - If the value exceeds DEPTH, the write is refused and `cfg_err_o` becomes 2'b01 on the next cycle.
  - If the value is below MIN_THR, the write is refused and `cfg_err_o` becomes 2'b10.
  - Otherwise the threshold is stored and `cfg_err_o` becomes 2'b00.
  - Any other configuration write sets `cfg_err_o` to 2'b00. Between writes `cfg_err_o` holds its value.
  - The thresholds reset to DEPTH (receive) and MIN_THR (transmit).
- R7: A shifter push into an enabled receive buffer that holds DEPTH samples drops the sample and sets status bit 2 (overrun). The bit is sticky.
- R8: A shifter pop from an enabled, empty transmit buffer sets status bit 3 (underrun), which is sticky. `ser_tx_data_o` is 0 whenever the transmit buffer is empty or disabled.
- R9: A pulse on `frame_err_i` sets status bit 4 (framing error), which is sticky.
- R10: Writing address 4 clears each of status bits 2 to 4 whose data bit is 1; bits 0 and 1 of that write are ignored. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: `irq_o` is the OR over the five status bits, each ANDed with the matching bit of the mask written at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_rx_push_i | input | 1 | Shifter pushes a received sample |
| ser_rx_data_i | input | DW | Received sample |
| ser_tx_pop_i | input | 1 | Shifter takes a sample to send |
| ser_tx_data_o | output | DW | Head of transmit buffer, 0 when empty |
| frame_err_i | input | 1 | Framing error pulse from shifter |
| host_rx_pop_i | input | 1 | Host takes a received sample |
| host_rx_data_o | output | DW | Head of receive buffer |
| host_tx_push_i | input | 1 | Host queues a sample to send |
| host_tx_data_i | input | DW | Sample to send |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration address |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cfg_err_o | output | 2 | Result of last configuration write |
| rx_level_o | output | LVL_W | Receive buffer fill level |
| tx_level_o | output | LVL_W | Transmit buffer fill level |
| status_o | output | 5 | Status flags |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench drives a full receive buffer into overrun. A design that accepted the extra sample would overwrite the oldest sample or let the level exceed DEPTH. It also drains an empty transmit buffer, where a faulty design would send stale data instead of zero.

Threshold writes of DEPTH+1 and 0 must leave the old threshold in place and report distinct codes. A design that stored them would move the full/empty flags; one that swapped the codes would misreport the error.

The bench issues a clear in the same cycle as a new underrun. If the design let the clear win, the event would be lost. It also disables a buffer while pushes continue; a design that kept counting would raise threshold flags from a disabled buffer.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;
  localparam int ST_W        = 5;
  localparam int ST_RX_FULL  = 0;
  localparam int ST_TX_EMPTY = 1;
  localparam int ST_RX_OVR   = 2;
  localparam int ST_TX_UNR   = 3;
  localparam int ST_FRM      = 4;

  typedef enum logic [2:0] {
    CFG_EN      = 3'd0,
    CFG_RX_THR  = 3'd1,
    CFG_TX_THR  = 3'd2,
    CFG_IRQ_MSK = 3'd3,
    CFG_CLR     = 3'd4
  } cfg_addr_e;

  typedef enum logic [1:0] {
    THR_OK   = 2'b00,
    THR_HIGH = 2'b01,
    THR_LOW  = 2'b10
  } thr_err_e;
endpackage

// File: rtl/aud_sfifo.sv
module aud_sfifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pop_i,
  output logic [DW-1:0]    rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem[rd_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= wdata_i;
  end

  p_level_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_W'(DEPTH));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> $stable(lvl_q));

  p_flush_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/aud_cfg_regs.sv
module aud_cfg_regs
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int MIN_THR = 1,
  parameter int CFG_W   = 8,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic [LVL_W-1:0] rx_thr_o,
  output logic [LVL_W-1:0] tx_thr_o,
  output logic [ST_W-1:0]  irq_msk_o,
  output logic [ST_W-1:0]  clr_o,
  output logic [1:0]       err_o
);
  logic [1:0]       en_q;
  logic [LVL_W-1:0] rx_thr_q, tx_thr_q;
  logic [ST_W-1:0]  msk_q;
  logic [1:0]       err_q;
  logic             too_high, too_low, thr_wr;

  assign too_high = wdata_i > CFG_W'(DEPTH);
  assign too_low  = wdata_i < CFG_W'(MIN_THR);
  assign thr_wr   = we_i && (addr_i == CFG_RX_THR || addr_i == CFG_TX_THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      rx_thr_q <= LVL_W'(DEPTH);
      tx_thr_q <= LVL_W'(MIN_THR);
      msk_q    <= '0;
      err_q    <= THR_OK;
    end else if (we_i) begin
      err_q <= THR_OK;
      if (thr_wr && too_high)     err_q <= THR_HIGH;
      else if (thr_wr && too_low) err_q <= THR_LOW;
      else if (addr_i == CFG_RX_THR) rx_thr_q <= LVL_W'(wdata_i);
      else if (addr_i == CFG_TX_THR) tx_thr_q <= LVL_W'(wdata_i);
      if (addr_i == CFG_EN)      en_q  <= wdata_i[1:0];
      if (addr_i == CFG_IRQ_MSK) msk_q <= wdata_i[ST_W-1:0];
    end
  end

  // only sticky bits are clearable
  assign clr_o = (we_i && addr_i == CFG_CLR) ?
                 (wdata_i[ST_W-1:0] & 5'b11100) : '0;

  assign rx_en_o   = en_q[0];
  assign tx_en_o   = en_q[1];
  assign rx_thr_o  = rx_thr_q;
  assign tx_thr_o  = tx_thr_q;
  assign irq_msk_o = msk_q;
  assign err_o     = err_q;

  p_thr_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CFG_RX_THR && (too_high || too_low)) |=> $stable(rx_thr_o));

  p_thr_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_thr_o <= LVL_W'(DEPTH) && tx_thr_o >= LVL_W'(MIN_THR));

  p_err_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr && too_high) |=> err_o == THR_HIGH);
endmodule

// File: rtl/aud_flag_unit.sv
module aud_flag_unit
  import aud_fifo_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic             ovr_set_i,
  input  logic             unr_set_i,
  input  logic             frm_set_i,
  input  logic [ST_W-1:0]  clr_i,
  input  logic [ST_W-1:0]  msk_i,
  output logic [ST_W-1:0]  status_o,
  output logic             irq_o
);
  logic [ST_W-1:0] set_vec, sticky_q;

  assign set_vec = {frm_set_i, unr_set_i, ovr_set_i, 2'b00};

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= ((sticky_q & ~clr_i) | set_vec) & 5'b11100;
  end

  always_comb begin
    status_o              = sticky_q;
    status_o[ST_RX_FULL]  = rx_en_i && (rx_lvl_i >= rx_thr_i);
    status_o[ST_TX_EMPTY] = tx_en_i && (tx_lvl_i <= tx_thr_i);
  end

  assign irq_o = |(status_o & msk_i);

  p_ovr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set_i |=> status_o[ST_RX_OVR]);

  p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_RX_OVR] && !clr_i[ST_RX_OVR]) |=> status_o[ST_RX_OVR]);

  p_unr_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[ST_TX_UNR] && !unr_set_i) |=> !status_o[ST_TX_UNR]);

  p_irq_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_i == '0) |-> !irq_o);
endmodule

// File: rtl/audio_phase_fifo_ctrl.sv
module audio_phase_fifo_ctrl
  import aud_fifo_pkg::*;
#(
  parameter int DW      = 16,
  parameter int DEPTH   = 8,
  parameter int MIN_THR = 1,
  parameter int CFG_W   = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_rx_push_i,
  input  logic [DW-1:0]    ser_rx_data_i,
  input  logic             ser_tx_pop_i,
  output logic [DW-1:0]    ser_tx_data_o,
  input  logic             frame_err_i,
  input  logic             host_rx_pop_i,
  output logic [DW-1:0]    host_rx_data_o,
  input  logic             host_tx_push_i,
  input  logic [DW-1:0]    host_tx_data_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [1:0]       cfg_err_o,
  output logic [LVL_W-1:0] rx_level_o,
  output logic [LVL_W-1:0] tx_level_o,
  output logic [ST_W-1:0]  status_o,
  output logic             irq_o
);
  logic             rx_en, tx_en;
  logic [LVL_W-1:0] rx_thr, tx_thr;
  logic [ST_W-1:0]  msk, clr;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic [DW-1:0]    tx_head;

  aud_cfg_regs #(
    .DEPTH(DEPTH), .MIN_THR(MIN_THR), .CFG_W(CFG_W), .LVL_W(LVL_W)
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rx_en_o(rx_en), .tx_en_o(tx_en),
    .rx_thr_o(rx_thr), .tx_thr_o(tx_thr),
    .irq_msk_o(msk), .clr_o(clr), .err_o(cfg_err_o)
  );

  aud_sfifo #(.DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W)) i_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i(!rx_en),
    .push_i(ser_rx_push_i), .wdata_i(ser_rx_data_i),
    .pop_i(host_rx_pop_i), .rdata_o(host_rx_data_o),
    .level_o(rx_level_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  aud_sfifo #(.DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W)) i_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i(!tx_en),
    .push_i(host_tx_push_i), .wdata_i(host_tx_data_i),
    .pop_i(ser_tx_pop_i), .rdata_o(tx_head),
    .level_o(tx_level_o), .full_o(tx_full), .empty_o(tx_empty)
  );

  assign ser_tx_data_o = (tx_en && !tx_empty) ? tx_head : '0;

  aud_flag_unit #(.LVL_W(LVL_W)) i_flags (
    .clk_i, .rst_ni,
    .rx_en_i(rx_en), .tx_en_i(tx_en),
    .rx_lvl_i(rx_level_o), .tx_lvl_i(tx_level_o),
    .rx_thr_i(rx_thr), .tx_thr_i(tx_thr),
    .ovr_set_i(rx_en && ser_rx_push_i && rx_full),
    .unr_set_i(tx_en && ser_tx_pop_i && tx_empty),
    .frm_set_i(frame_err_i),
    .clr_i(clr), .msk_i(msk),
    .status_o, .irq_o
  );

  p_no_phantom_rx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> rx_level_o == '0);

  p_tx_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full && !ser_tx_pop_i && tx_en) |=> tx_level_o == LVL_W'(DEPTH));
endmodule

// File: tb/test_audio_phase_fifo_ctrl.sv
`timescale 1ns/100ps
module test_audio_phase_fifo_ctrl;
  localparam int DW = 16, DEPTH = 8, MIN_THR = 1, CFG_W = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk_i = 0, rst_ni = 0;
  logic ser_rx_push_i, ser_tx_pop_i, frame_err_i, host_rx_pop_i, host_tx_push_i, cfg_we_i;
  logic [DW-1:0] ser_rx_data_i, host_tx_data_i, ser_tx_data_o, host_rx_data_o;
  logic [2:0] cfg_addr_i;
  logic [CFG_W-1:0] cfg_wdata_i;
  logic [1:0] cfg_err_o;
  logic [LVL_W-1:0] rx_level_o, tx_level_o;
  logic [4:0] status_o;
  logic irq_o;

  audio_phase_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH), .MIN_THR(MIN_THR), .CFG_W(CFG_W))
  i_audio_phase_fifo_ctrl (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [DW-1:0] rx_q[$], tx_q[$];
  logic [1:0] m_en;
  int m_rx_thr, m_tx_thr;
  logic [4:0] m_msk;
  logic [2:0] m_st;   // ovr, unr, frm
  logic [1:0] m_err;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_status();
    logic [4:0] s;
    s[0] = m_en[0] && (rx_q.size() >= m_rx_thr);
    s[1] = m_en[1] && (tx_q.size() <= m_tx_thr);
    s[4:2] = m_st;
    return s;
  endfunction

  task automatic model_reset();
    rx_q.delete(); tx_q.delete();
    m_en = 0; m_rx_thr = DEPTH; m_tx_thr = MIN_THR; m_msk = 0; m_st = 0; m_err = 0;
  endtask

  task automatic model_step();
    int rxs, txs;
    logic [2:0] set, clr;
    rxs = rx_q.size(); txs = tx_q.size(); set = 0; clr = 0;
    if (!m_en[0]) rx_q.delete();
    else begin
      if (host_rx_pop_i && rxs > 0) void'(rx_q.pop_front());
      if (ser_rx_push_i) begin
        if (rxs < DEPTH) rx_q.push_back(ser_rx_data_i);
        else set[0] = 1;
      end
    end
    if (!m_en[1]) tx_q.delete();
    else begin
      if (ser_tx_pop_i) begin
        if (txs > 0) void'(tx_q.pop_front());
        else set[1] = 1;
      end
      if (host_tx_push_i && txs < DEPTH) tx_q.push_back(host_tx_data_i);
    end
    set[2] = frame_err_i;
    if (cfg_we_i) begin
      m_err = 0;
      case (cfg_addr_i)
        3'd0: m_en = cfg_wdata_i[1:0];
        3'd1, 3'd2: begin
          if (cfg_wdata_i > DEPTH) m_err = 2'b01;
          else if (cfg_wdata_i < MIN_THR) m_err = 2'b10;
          else if (cfg_addr_i == 3'd1) m_rx_thr = cfg_wdata_i;
          else m_tx_thr = cfg_wdata_i;
        end
        3'd3: m_msk = cfg_wdata_i[4:0];
        3'd4: clr = cfg_wdata_i[4:2];
        default: ;
      endcase
    end
    m_st = (m_st & ~clr) | set;
  endtask

  task automatic check_all();
    logic [4:0] es;
    es = exp_status();
    chk("R2/R3 rx level", rx_level_o, rx_q.size());
    chk("R2/R3 tx level", tx_level_o, tx_q.size());
    if (rx_q.size() > 0) chk("R2 rx head", host_rx_data_o, rx_q[0]);
    chk("R8 R2 tx data", ser_tx_data_o, (m_en[1] && tx_q.size() > 0) ? tx_q[0] : 0);
    chk("R4 rx full", status_o[0], es[0]);
    chk("R5 tx empty", status_o[1], es[1]);
    chk("R7 R10 overrun", status_o[2], es[2]);
    chk("R8 R10 underrun", status_o[3], es[3]);
    chk("R9 R10 framing", status_o[4], es[4]);
    chk("R11 irq", irq_o, |(es & m_msk));
    chk("R6 cfg err", cfg_err_o, m_err);
  endtask

  task automatic idle();
    ser_rx_push_i = 0; ser_tx_pop_i = 0; frame_err_i = 0; host_rx_pop_i = 0;
    host_tx_push_i = 0; cfg_we_i = 0; cfg_addr_i = 0; cfg_wdata_i = 0;
    ser_rx_data_i = 0; host_tx_data_i = 0;
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    check_all();
    idle();
  endtask

  task automatic cfg_wr(input int a, input int d);
    cfg_we_i = 1; cfg_addr_i = 3'(a); cfg_wdata_i = CFG_W'(d);
    cyc();
  endtask

  initial begin
    idle();
    model_reset();
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    chk("R1 rx level", rx_level_o, 0);
    chk("R1 tx level", tx_level_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 cfg err", cfg_err_o, 0);
    rst_ni = 1;
    // disabled: pushes ignored (R3)
    ser_rx_push_i = 1; ser_rx_data_i = 16'h1111; host_tx_push_i = 1; cyc();
    cfg_wr(0, 3);
    cfg_wr(1, DEPTH + 1);   // R6 too high
    cfg_wr(1, 0);           // R6 too low
    cfg_wr(2, DEPTH + 1);
    cfg_wr(1, 4);
    cfg_wr(2, 2);
    cfg_wr(3, 5'h1f);
    // fill rx to overrun (R7)
    for (int i = 0; i < DEPTH + 2; i++) begin
      ser_rx_push_i = 1; ser_rx_data_i = DW'(16'hA000 + i); cyc();
    end
    for (int i = 0; i < DEPTH; i++) begin
      host_rx_pop_i = 1; cyc();
    end
    // underrun (R8)
    ser_tx_pop_i = 1; cyc();
    for (int i = 0; i < 3; i++) begin
      host_tx_push_i = 1; host_tx_data_i = DW'(16'hB000 + i); cyc();
    end
    for (int i = 0; i < 3; i++) begin
      ser_tx_pop_i = 1; cyc();
    end
    frame_err_i = 1; cyc();  // R9
    cfg_wr(4, 5'h1f);        // R10 clear
    // set and clear same cycle (R10)
    ser_tx_pop_i = 1; cfg_we_i = 1; cfg_addr_i = 3'd4; cfg_wdata_i = 8'h08; cyc();
    cfg_wr(3, 0);            // R11 mask off
    frame_err_i = 1; cyc();
    // disable rx while pushing (R3)
    ser_rx_push_i = 1; ser_rx_data_i = 16'h5555; cyc();
    cfg_wr(0, 2);
    ser_rx_push_i = 1; cyc();
    ser_rx_push_i = 1; cyc();
    cfg_wr(0, 3);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      ser_rx_push_i  = $urandom % 2;
      ser_rx_data_i  = DW'($urandom);
      host_rx_pop_i  = ($urandom % 3) == 0;
      host_tx_push_i = $urandom % 2;
      host_tx_data_i = DW'($urandom);
      ser_tx_pop_i   = ($urandom % 3) == 0;
      frame_err_i    = ($urandom % 40) == 0;
      if (($urandom % 12) == 0) begin
        cfg_we_i = 1;
        cfg_addr_i = 3'($urandom % 8);
        cfg_wdata_i = (cfg_addr_i == 3'd0) ? CFG_W'(($urandom % 8) == 0 ? 1 : 3)
                                           : CFG_W'($urandom % 12);
        if (cfg_addr_i == 3'd0 && ($urandom % 4) == 0) cfg_wdata_i = CFG_W'($urandom % 4);
      end
      cyc();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule